// File: doc/BRIEF.md
# Tamper Self-Destruct Controller

This block guards the secret state of a secure processor. It watches an active-high tamper input and, once a high level on that input has been confirmed, erases that state in a fixed order. First it zeroes a 64-bit encryption key register. Then it overwrites every word of a small vector RAM with zero. Last, it drops the enable of the switched memory supply for a set number of cycles. A done flag then rises and stays up until the next reset.

The tamper input passes a two-stage synchronizer and then a run-length filter. Only an unbroken run of high samples of the acceptance length starts the sequence. Shorter runs are dropped, and so are runs split by a single low sample. Once started, the sequence cannot be stopped or restarted by further tamper activity.

The vector RAM is loaded through a valid/ready write port. A word is taken on any clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high only while the controller is armed and idle. From the cycle the sequence starts until the next reset, `wr_ready` stays low and the port accepts nothing. A source holding `wr_valid` simply waits, and no word is ever half-taken. A combinational read port shows the RAM contents. Reset reloads the key from a parameter seed. Reset does not touch the RAM.

Top module: `tamper_destruct`

## Requirements
- R1: After reset, `key_out` equals the parameter KEY_SEED, `pwr_en` is 1, `done` is 0 and `wr_ready` is 1.
- R2: A high run on `tamper_raw` shorter than REJECT_CYC cycles leaves the key, `pwr_en`, `done` and `wr_ready` unchanged.
- R3: Destruction starts only after ACCEPT_CYC consecutive high samples. One low sample resets the count, so two runs of ACCEPT_CYC-1 highs separated by a low do not trigger.
- R4: The key becomes all zeros before any RAM word is wiped, and it is zero whenever `pwr_en` is low.
- R5: The wipe writes zero to each vector RAM word, one word per cycle, at ascending addresses from 0 to DEPTH-1. Afterwards every address reads 0.
- R6: After the wipe, `pwr_en` goes low for exactly PWR_CYC consecutive cycles. It is then 1 again and stays 1.
- R7: `done` rises when the power pulse ends and stays 1 until reset. Tamper activity after the sequence has started has no effect, so `pwr_en` does not drop a second time.
- R8: A write is taken when `wr_valid` and `wr_ready` are both high, and the data reads back at `rd_addr` on the next cycle. `wr_ready` is 0 from the start of destruction until reset, and writes offered while it is 0 change no word.
- R9: A later reset re-arms the block and reloads the key seed, but it leaves the wiped RAM words at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tamper_raw | input | 1 | Asynchronous active-high tamper request |
| wr_valid | input | 1 | Vector RAM write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_addr | input | ADDR_W | Vector RAM write address |
| wr_data | input | DATA_W | Vector RAM write data |
| rd_addr | input | ADDR_W | Vector RAM read address |
| rd_data | output | DATA_W | Vector RAM read data (combinational) |
| key_out | output | KEY_W | Encryption key register |
| pwr_en | output | 1 | Switched memory supply enable, active high |
| done | output | 1 | Destruction finished, sticky until reset |

## Verification
The bench drives tamper runs of exactly REJECT_CYC-1 cycles and runs of ACCEPT_CYC-1 cycles split by one low sample. A filter that counted total rather than consecutive samples, or that compared against the wrong threshold, would wipe the key on these runs. The length of the power-off window is counted cycle by cycle, so an off-by-one in the timer shows up as a window one cycle too long or too short.

At the first power-off cycle the bench reads back the key and every RAM word. A sequence that ran its steps out of order would still show secret data at that point. After completion it retriggers the tamper input and offers a write. A controller that re-armed would pulse the supply again, and an open write port would leave the written word in RAM. After a second reset it checks that the key seed is back and that the RAM has stayed zero.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  typedef enum logic [2:0] {
    ST_ARMED = 3'd0,
    ST_KEY   = 3'd1,
    ST_WIPE  = 3'd2,
    ST_PWR   = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/tamper_filter.sv
module tamper_filter #(
  parameter int REJECT_CYC = 3,
  parameter int ACCEPT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic fire
);
  localparam int CNT_W = $clog2(ACCEPT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ACCEPT_CYC - 1);

  logic [1:0]       sync_q;
  logic             samp;
  logic [CNT_W-1:0] run_q;

  assign samp = sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (!samp)
        run_q <= '0;
      else if (run_q < CNT_TOP)
        run_q <= run_q + 1'b1;
    end
  end

  // fire needs a full run of ACCEPT_CYC high samples; REJECT_CYC < ACCEPT_CYC
  assign fire = samp && (run_q == CNT_TOP);

  // R3
  fire_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(samp));
endmodule

// File: rtl/tamper_vram.sv
module tamper_vram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tamper_fsm.sv
module tamper_fsm
  import tamper_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int PWR_CYC = 20,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PC_W   = $clog2(PWR_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  output logic              armed,
  output logic              key_clr,
  output logic              wipe_we,
  output logic [ADDR_W-1:0] wipe_addr,
  output logic              pwr_en,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [PC_W-1:0]   LAST_PWR  = PC_W'(PWR_CYC - 1);

  seq_state_t       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PC_W-1:0]   pcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARMED;
      addr_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (fire) state_q <= ST_KEY;
        ST_KEY: begin
          addr_q  <= '0;
          state_q <= ST_WIPE;
        end
        ST_WIPE: begin
          if (addr_q == LAST_ADDR) begin
            pcnt_q  <= '0;
            state_q <= ST_PWR;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_PWR: begin
          if (pcnt_q == LAST_PWR) state_q <= ST_DONE;
          else                    pcnt_q  <= pcnt_q + 1'b1;
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_ARMED;
      endcase
    end
  end

  assign armed     = (state_q == ST_ARMED);
  assign key_clr   = (state_q == ST_KEY);
  assign wipe_we   = (state_q == ST_WIPE);
  assign wipe_addr = addr_q;
  assign pwr_en    = (state_q != ST_PWR);
  assign done      = (state_q == ST_DONE);

  // R7
  no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !armed);
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R5
  wipe_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wipe_we && $past(wipe_we)) |-> (wipe_addr == $past(wipe_addr) + 1'b1));
endmodule

// File: rtl/tamper_destruct.sv
module tamper_destruct #(
  parameter int          KEY_W      = 64,
  parameter logic [63:0] KEY_SEED   = 64'h0123_4567_89AB_CDEF,
  parameter int          DEPTH      = 16,
  parameter int          DATA_W     = 8,
  parameter int          REJECT_CYC = 3,
  parameter int          ACCEPT_CYC = 8,
  parameter int          PWR_CYC    = 20,
  localparam int         ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tamper_raw,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [KEY_W-1:0]  key_out,
  output logic              pwr_en,
  output logic              done
);
  logic              fire, armed, key_clr, wipe_we;
  logic [ADDR_W-1:0] wipe_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic [KEY_W-1:0]  key_q;

  tamper_filter #(.REJECT_CYC(REJECT_CYC), .ACCEPT_CYC(ACCEPT_CYC)) u_filter (
    .clk(clk), .rst(rst), .raw(tamper_raw), .fire(fire));

  tamper_fsm #(.DEPTH(DEPTH), .PWR_CYC(PWR_CYC)) u_fsm (
    .clk(clk), .rst(rst), .fire(fire), .armed(armed), .key_clr(key_clr),
    .wipe_we(wipe_we), .wipe_addr(wipe_addr), .pwr_en(pwr_en), .done(done));

  always_ff @(posedge clk) begin
    if (rst)          key_q <= KEY_SEED[KEY_W-1:0];
    else if (key_clr) key_q <= '0;
  end

  assign wr_ready = armed;
  assign mem_we   = wipe_we || (wr_valid && wr_ready);
  assign mem_addr = wipe_we ? wipe_addr : wr_addr;
  assign mem_data = wipe_we ? '0 : wr_data;

  tamper_vram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_vram (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_data),
    .raddr(rd_addr), .rdata(rd_data));

  assign key_out = key_q;

  // R4
  key_before_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    wipe_we |-> (key_q == '0));
  // R4
  key_before_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |-> (key_q == '0));
  // R8
  no_user_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !armed && !wipe_we) |-> !mem_we);
endmodule

// File: tb/tamper_destruct_bench.sv
`timescale 1ns/1ps
module tamper_destruct_bench;
  localparam int          KEY_W = 64;
  localparam logic [63:0] SEED  = 64'h0123_4567_89AB_CDEF;
  localparam int DEPTH = 16, DATA_W = 8, REJ = 3, ACC = 8, PWR = 20;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 0, rst = 1, tamper_raw = 0, wr_valid = 0;
  logic wr_ready, pwr_en, done;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [KEY_W-1:0]  key_out;

  int checks = 0, fails = 0;
  logic [ADDR_W+DATA_W-1:0] sb_q[$];

  always #10 clk = ~clk;

  tamper_destruct #(.KEY_W(KEY_W), .KEY_SEED(SEED), .DEPTH(DEPTH), .DATA_W(DATA_W),
    .REJECT_CYC(REJ), .ACCEPT_CYC(ACC), .PWR_CYC(PWR)) u_tamper_destruct (
    .clk(clk), .rst(rst), .tamper_raw(tamper_raw), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .key_out(key_out), .pwr_en(pwr_en), .done(done));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: offer one write, push expected item when it is accepted
  task automatic drive_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    wr_valid = 1; wr_addr = a; wr_data = d;
    if (wr_ready) sb_q.push_back({a, d});
    cyc(1);
    wr_valid = 0;
  endtask

  // monitor: pop each expected item and compare the RAM read port
  task automatic scoreboard(input string req);
    while (sb_q.size() > 0) begin
      logic [ADDR_W+DATA_W-1:0] it;
      it = sb_q.pop_front();
      rd_addr = it[ADDR_W+DATA_W-1:DATA_W];
      #0.1;
      chk(req, 64'(rd_data), 64'(it[DATA_W-1:0]));
    end
  endtask

  task automatic expect_ram_zero(input string req);
    for (int a = 0; a < DEPTH; a++) sb_q.push_back({ADDR_W'(a), DATA_W'(0)});
    scoreboard(req);
  endtask

  task automatic pulse(input int n);
    tamper_raw = 1; cyc(n); tamper_raw = 0;
  endtask

  task automatic check_idle(input string req);
    chk(req, key_out, SEED);
    chk(req, 64'(pwr_en), 64'd1);
    chk(req, 64'(done), 64'd0);
    chk(req, 64'(wr_ready), 64'd1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lows, first_low_seen;
    cyc(3); rst = 0; cyc(1);
    check_idle("R1");

    // R8: load RAM and read back
    for (int a = 0; a < DEPTH; a++) drive_write(ADDR_W'(a), DATA_W'(8'h30 + a));
    scoreboard("R8");

    // R2: short run is rejected
    pulse(REJ - 1); cyc(20);
    check_idle("R2");

    // R3: broken run of sub-acceptance highs does not trigger
    tamper_raw = 1; cyc(ACC - 1); tamper_raw = 0; cyc(1);
    tamper_raw = 1; cyc(ACC - 1); tamper_raw = 0; cyc(20);
    check_idle("R3");

    // R3: exact acceptance run triggers
    pulse(ACC);
    lows = 0; first_low_seen = 0;
    for (int i = 0; i < 200 && !done; i++) begin
      if (i == 6) chk("R8", 64'(wr_ready), 64'd0);
      if (!pwr_en) begin
        lows++;
        if (!first_low_seen) begin
          first_low_seen = 1;
          chk("R4", key_out, 64'd0);
          expect_ram_zero("R5");
        end
      end
      cyc(1);
    end
    chk("R3", 64'(done), 64'd1);
    chk("R6", 64'(lows), 64'(PWR));
    chk("R6", 64'(pwr_en), 64'd1);
    expect_ram_zero("R5");

    // R7: tamper after completion is ignored
    tamper_raw = 1;
    for (int i = 0; i < 3 * ACC; i++) begin
      if (!pwr_en || !done) begin
        chk("R7", {62'd0, pwr_en, done}, 64'd3);
      end
      cyc(1);
    end
    tamper_raw = 0;
    chk("R7", 64'(done), 64'd1);

    // R8: write while not ready changes nothing
    chk("R8", 64'(wr_ready), 64'd0);
    drive_write(ADDR_W'(3), 8'hA5);
    cyc(1);
    rd_addr = ADDR_W'(3); #0.1;
    chk("R8", 64'(rd_data), 64'd0);

    // R9: reset re-arms, RAM stays wiped
    rst = 1; cyc(2); rst = 0; cyc(1);
    check_idle("R9");
    expect_ram_zero("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule